// File: doc/BRIEF.md
# Deduplicating Write-Path Mapping Controller

This controller carries one logical-page command at a time through a content-addressed translation layer. A write arrives with its logical page number and a content hash produced by an external hashing engine. The controller looks the hash up in a small fully associative cache of recently seen values. If the value is already stored, the logical page is repointed at the physical page holding it and the command finishes with no flash program. If the value is not stored, the controller asks the flash back end to program the next unused physical page. Once that program is acknowledged, it records the new value in the cache.

Each physical page carries a saturating reference count of the logical pages that point at it. When a logical page leaves its old physical page, that page's count is decremented. When the count reaches zero, the page is reported invalid and its hash is dropped from the cache, so a later write of the same value is programmed afresh. A read is answered from the logical-to-physical table alone. Victim selection and flash timing are handled elsewhere.

Top module: `dedup_write_ctrl`

## Requirements
- R1: A read accepted at a clock edge sets done_o for one cycle after that edge. It returns done_ppn_o from the logical table and sets done_mapped_o to 1 only if the logical page was ever written. It issues no flash request and has done_hit_o at 0.
- R2: A write whose hash misses raises flash_req_valid_o with flash_req_ppn_o equal to the next unused physical page. Pages are handed out in ascending order from 0. done_o follows one cycle after the edge where flash_req_ready_i is sampled high, with done_hit_o at 0 and done_ppn_o equal to the programmed page.
- R3: A write whose hash hits a page with a non-saturated count issues no flash request. done_o rises two cycles after acceptance, with done_hit_o at 1 and done_ppn_o equal to the cached page.
- R4: flash_req_valid_o and flash_req_ppn_o hold steady until flash_req_ready_i is high. Mapping tables change only on the acknowledging edge.
- R5: cmd_ready_o is 1 only in the idle state. It stays 0 while a write is in lookup, waiting on flash, or stalled.
- R6: Rewriting a logical page with the content it already maps to reports done_hit_o at 1 and the same page. It causes no invalidation and no counter change.
- R7: When the last logical page leaves a physical page, inval_o pulses together with done_o and inval_ppn_o names that page. A later write of that value misses and programs a fresh page.
- R8: Dropping the hash of an invalidated page whose cache entry was already evicted has no effect. err_o stays 0 and the other cache entries still hit.
- R9: When the cache is full, an insertion replaces the least recently hit or inserted entry. The evicted value then misses.
- R10: A hit on a page whose reference count is at its maximum (all ones) is handled as a miss. The value is programmed to a new page and the cache entry for it is redirected to that page.
- R11: err_o goes high and stays high if a decrement is applied to a zero count. It never rises in legal operation.
- R12: stall_o is 1 while every physical page has been allocated. A missing write then waits with no flash request and cmd_ready_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_lpn_i | input | LPN_W | Logical page number |
| cmd_hash_i | input | HASH_W | Content hash of the write data |
| cmd_ready_o | output | 1 | Controller idle, command accepted this cycle |
| done_o | output | 1 | Command finished (one-cycle pulse) |
| done_hit_o | output | 1 | Write finished without a flash program |
| done_mapped_o | output | 1 | Read target has a mapping (1 for writes) |
| done_ppn_o | output | PPN_W | Physical page of the finished command |
| inval_o | output | 1 | A physical page lost its last reference |
| inval_ppn_o | output | PPN_W | Page invalidated |
| flash_req_valid_o | output | 1 | Flash program request |
| flash_req_ppn_o | output | PPN_W | Page to program |
| flash_req_ready_i | input | 1 | Flash program acknowledged |
| stall_o | output | 1 | No free physical page left |
| err_o | output | 1 | Sticky reference-count underflow |

## Verification
The bench builds the controller with 8 logical pages, 6 physical pages, a 3-entry hash cache and 2-bit reference counters. With these values, four logical pages sharing one value saturate a counter, three distinct values fill the cache and force an eviction, and six misses use up the page pool. All three corner paths, plus the removal of an already-evicted entry, are therefore reached in a short sequence whose page numbers are worked out by hand.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_PROGRAM,
    ST_STALL
  } wr_state_e;
endpackage

// File: rtl/dwc_hash_cache.sv
module dwc_hash_cache #(
  parameter int HASH_W = 32,
  parameter int PPN_W  = 5,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HASH_W-1:0] key_i,
  output logic              hit_o,
  output logic [PPN_W-1:0]  hit_ppn_o,
  input  logic              touch_i,
  input  logic              insert_i,
  input  logic [PPN_W-1:0]  insert_ppn_i,
  input  logic              remove_i,
  input  logic [PPN_W-1:0]  remove_ppn_i
);
  logic [DEPTH-1:0]  vld_q;
  logic [HASH_W-1:0] key_q [DEPTH];
  logic [PPN_W-1:0]  ppn_q [DEPTH];
  logic [IDX_W-1:0]  age_q [DEPTH];

  logic [IDX_W-1:0] hit_idx, vict_idx, tgt_idx, mru_idx;
  logic             mru_en;

  always_comb begin
    hit_o   = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i] && key_q[i] == key_i) begin
        hit_o   = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  // free slot first, otherwise oldest
  always_comb begin
    vict_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (age_q[i] == IDX_W'(DEPTH - 1)) vict_idx = IDX_W'(i);
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_q[i]) vict_idx = IDX_W'(i);
  end

  assign hit_ppn_o = ppn_q[hit_idx];
  assign tgt_idx   = hit_o ? hit_idx : vict_idx;
  assign mru_en    = touch_i || insert_i;
  assign mru_idx   = insert_i ? tgt_idx : hit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        key_q[i] <= '0;
        ppn_q[i] <= '0;
        age_q[i] <= IDX_W'(i);
      end
    end else begin
      if (remove_i) begin
        for (int i = 0; i < DEPTH; i++)
          if (vld_q[i] && ppn_q[i] == remove_ppn_i) vld_q[i] <= 1'b0;
      end
      if (insert_i) begin
        vld_q[tgt_idx] <= 1'b1;
        key_q[tgt_idx] <= key_i;
        ppn_q[tgt_idx] <= insert_ppn_i;
      end
      if (mru_en) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (IDX_W'(i) == mru_idx)          age_q[i] <= '0;
          else if (age_q[i] < age_q[mru_idx]) age_q[i] <= age_q[i] + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dwc_page_refs.sv
module dwc_page_refs #(
  parameter int PPN_W = 5,
  parameter int REF_W = 3,
  localparam int SLOTS = 1 << PPN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PPN_W-1:0] rd_ppn_i,
  output logic [REF_W-1:0] rd_cnt_o,
  input  logic             inc_i,
  input  logic [PPN_W-1:0] inc_ppn_i,
  input  logic             dec_i,
  input  logic [PPN_W-1:0] dec_ppn_i,
  output logic             dec_last_o,
  output logic             err_o
);
  logic [REF_W-1:0] cnt_q [SLOTS];
  logic             err_q;

  assign rd_cnt_o   = cnt_q[rd_ppn_i];
  assign dec_last_o = cnt_q[dec_ppn_i] == REF_W'(1);
  assign err_o      = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      for (int i = 0; i < SLOTS; i++) cnt_q[i] <= '0;
    end else begin
      if (inc_i && cnt_q[inc_ppn_i] != '1)
        cnt_q[inc_ppn_i] <= cnt_q[inc_ppn_i] + REF_W'(1);
      if (dec_i) begin
        if (cnt_q[dec_ppn_i] == '0) err_q <= 1'b1;
        else cnt_q[dec_ppn_i] <= cnt_q[dec_ppn_i] - REF_W'(1);
      end
    end
  end
endmodule

// File: rtl/dedup_write_ctrl.sv
module dedup_write_ctrl
  import dwc_pkg::*;
#(
  parameter int NUM_LPN     = 64,
  parameter int NUM_PPN     = 32,
  parameter int HASH_W      = 32,
  parameter int CACHE_DEPTH = 8,
  parameter int REF_W       = 3,
  localparam int LPN_W      = $clog2(NUM_LPN),
  localparam int PPN_W      = $clog2(NUM_PPN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_write_i,
  input  logic [LPN_W-1:0]  cmd_lpn_i,
  input  logic [HASH_W-1:0] cmd_hash_i,
  output logic              cmd_ready_o,
  output logic              done_o,
  output logic              done_hit_o,
  output logic              done_mapped_o,
  output logic [PPN_W-1:0]  done_ppn_o,
  output logic              inval_o,
  output logic [PPN_W-1:0]  inval_ppn_o,
  output logic              flash_req_valid_o,
  output logic [PPN_W-1:0]  flash_req_ppn_o,
  input  logic              flash_req_ready_i,
  output logic              stall_o,
  output logic              err_o
);
  localparam int LSLOTS = 1 << LPN_W;
  localparam logic [PPN_W:0] POOL_END = NUM_PPN[PPN_W:0];

  wr_state_e         state_q, state_d;
  logic [LPN_W-1:0]  lpn_q;
  logic [HASH_W-1:0] hash_q;
  logic [PPN_W:0]    free_q;
  logic [PPN_W-1:0]  map_ppn_q [LSLOTS];
  logic [LSLOTS-1:0] map_vld_q;

  logic             done_q, done_hit_q, done_map_q, inval_q;
  logic [PPN_W-1:0] done_ppn_q, inval_ppn_q;

  logic             c_hit;
  logic [PPN_W-1:0] c_ppn;
  logic [REF_W-1:0] c_cnt;
  logic             dec_last;

  logic             accept, rd_acc, old_vld, same, take_hit, need_pgm, pool_dry;
  logic             fire, commit, dec_en, drop;
  logic [PPN_W-1:0] old_ppn, new_ppn, free_ppn;

  assign accept   = state_q == ST_IDLE && cmd_valid_i;
  assign rd_acc   = accept && !cmd_write_i;
  assign old_vld  = map_vld_q[lpn_q];
  assign old_ppn  = map_ppn_q[lpn_q];
  assign free_ppn = free_q[PPN_W-1:0];
  assign pool_dry = free_q == POOL_END;

  assign same     = state_q == ST_LOOKUP && c_hit && old_vld && old_ppn == c_ppn;
  // a saturated page cannot take another reference: fall back to a program
  assign take_hit = state_q == ST_LOOKUP && c_hit && !same && c_cnt != '1;
  assign need_pgm = state_q == ST_LOOKUP && !same && !take_hit;
  assign fire     = state_q == ST_PROGRAM && flash_req_ready_i;
  assign commit   = take_hit || fire;
  assign new_ppn  = take_hit ? c_ppn : free_ppn;
  assign dec_en   = commit && old_vld;
  assign drop     = dec_en && dec_last;

  dwc_hash_cache #(
    .HASH_W(HASH_W), .PPN_W(PPN_W), .DEPTH(CACHE_DEPTH)
  ) u_cache (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .key_i        (hash_q),
    .hit_o        (c_hit),
    .hit_ppn_o    (c_ppn),
    .touch_i      (take_hit || same),
    .insert_i     (fire),
    .insert_ppn_i (free_ppn),
    .remove_i     (drop),
    .remove_ppn_i (old_ppn)
  );

  dwc_page_refs #(
    .PPN_W(PPN_W), .REF_W(REF_W)
  ) u_refs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_ppn_i   (c_ppn),
    .rd_cnt_o   (c_cnt),
    .inc_i      (commit),
    .inc_ppn_i  (new_ppn),
    .dec_i      (dec_en),
    .dec_ppn_i  (old_ppn),
    .dec_last_o (dec_last),
    .err_o      (err_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept && cmd_write_i) state_d = ST_LOOKUP;
      ST_LOOKUP:  if (need_pgm) state_d = pool_dry ? ST_STALL : ST_PROGRAM;
                  else          state_d = ST_IDLE;
      ST_PROGRAM: if (fire) state_d = ST_IDLE;
      ST_STALL:   state_d = ST_STALL;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lpn_q       <= '0;
      hash_q      <= '0;
      free_q      <= '0;
      map_vld_q   <= '0;
      done_q      <= 1'b0;
      done_hit_q  <= 1'b0;
      done_map_q  <= 1'b0;
      done_ppn_q  <= '0;
      inval_q     <= 1'b0;
      inval_ppn_q <= '0;
      for (int i = 0; i < LSLOTS; i++) map_ppn_q[i] <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        lpn_q  <= cmd_lpn_i;
        hash_q <= cmd_hash_i;
      end
      if (commit) begin
        map_ppn_q[lpn_q] <= new_ppn;
        map_vld_q[lpn_q] <= 1'b1;
      end
      if (fire) free_q <= free_q + 1'b1;
      done_q      <= rd_acc || commit || same;
      done_hit_q  <= take_hit || same;
      done_map_q  <= rd_acc ? map_vld_q[cmd_lpn_i] : 1'b1;
      done_ppn_q  <= rd_acc ? map_ppn_q[cmd_lpn_i] : (same ? c_ppn : new_ppn);
      inval_q     <= drop;
      inval_ppn_q <= old_ppn;
    end
  end

  assign cmd_ready_o       = state_q == ST_IDLE;
  assign flash_req_valid_o = state_q == ST_PROGRAM;
  assign flash_req_ppn_o   = free_ppn;
  assign stall_o           = pool_dry;
  assign done_o            = done_q;
  assign done_hit_o        = done_hit_q;
  assign done_mapped_o     = done_map_q;
  assign done_ppn_o        = done_ppn_q;
  assign inval_o           = inval_q;
  assign inval_ppn_o       = inval_ppn_q;
endmodule

// File: rtl/dwc_checker.sv
module dwc_checker #(
  parameter int PPN_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_ready_o,
  input logic             flash_req_valid_o,
  input logic [PPN_W-1:0] flash_req_ppn_o,
  input logic             flash_req_ready_i,
  input logic             done_o,
  input logic             done_hit_o,
  input logic             inval_o,
  input logic             stall_o,
  input logic             err_o
);
  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_req_valid_o && !flash_req_ready_i |=> flash_req_valid_o && $stable(flash_req_ppn_o));

  assert_busy_not_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_req_valid_o |-> !cmd_ready_o);

  assert_ack_completes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_req_valid_o && flash_req_ready_i |=> done_o && !done_hit_o);

  assert_hit_no_program_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && done_hit_o |-> !$past(flash_req_valid_o));

  assert_inval_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_o |-> done_o);

  assert_no_underflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o);

  assert_stall_no_request_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !flash_req_valid_o);
endmodule

bind dedup_write_ctrl dwc_checker #(.PPN_W(PPN_W)) u_dwc_checker (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .cmd_ready_o       (cmd_ready_o),
  .flash_req_valid_o (flash_req_valid_o),
  .flash_req_ppn_o   (flash_req_ppn_o),
  .flash_req_ready_i (flash_req_ready_i),
  .done_o            (done_o),
  .done_hit_o        (done_hit_o),
  .inval_o           (inval_o),
  .stall_o           (stall_o),
  .err_o             (err_o)
);

// File: tb/dedup_write_ctrl_bench.sv
module dedup_write_ctrl_bench;
  localparam int NL = 8, NP = 6, HW = 16, CD = 3, RW = 2;
  localparam int LW = 3, PW = 3;
  localparam logic [HW-1:0] HA = 16'hA001, HB = 16'hB002, HC = 16'hC003, HD = 16'hD004;

  typedef struct packed {
    logic          wr;
    logic [LW-1:0] lpn;
    logic [HW-1:0] hash;
    logic [PW-1:0] ppn;
    logic          flash;
    logic          hit;
    logic          inval;
    logic [PW-1:0] ippn;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, HA, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, 4'd2},  // R2 first miss
    '{1'b1, 3'd1, HA, 3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 4'd3},  // R3 hit
    '{1'b1, 3'd2, HB, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 4'd2},
    '{1'b0, 3'd1, 16'h0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 4'd1},  // R1 read
    '{1'b1, 3'd0, HA, 3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 4'd6},  // R6 same content
    '{1'b1, 3'd0, HC, 3'd2, 1'b1, 1'b0, 1'b0, 3'd0, 4'd2},
    '{1'b1, 3'd1, HB, 3'd1, 1'b0, 1'b1, 1'b1, 3'd0, 4'd7},  // R7 page 0 freed
    '{1'b1, 3'd3, HA, 3'd3, 1'b1, 1'b0, 1'b0, 3'd0, 4'd7},  // R7 value reprogrammed
    '{1'b1, 3'd4, HA, 3'd3, 1'b0, 1'b1, 1'b0, 3'd0, 4'd3},
    '{1'b1, 3'd5, HA, 3'd3, 1'b0, 1'b1, 1'b0, 3'd0, 4'd3},
    '{1'b1, 3'd6, HA, 3'd4, 1'b1, 1'b0, 1'b0, 3'd0, 4'd10}, // R10 saturated
    '{1'b1, 3'd7, HA, 3'd4, 1'b0, 1'b1, 1'b0, 3'd0, 4'd10},
    '{1'b0, 3'd6, 16'h0, 3'd4, 1'b0, 1'b0, 1'b0, 3'd0, 4'd1},
    '{1'b1, 3'd0, HC, 3'd2, 1'b0, 1'b1, 1'b0, 3'd0, 4'd6},  // R6 also refreshes C
    '{1'b1, 3'd0, HD, 3'd5, 1'b1, 1'b0, 1'b1, 3'd2, 4'd9},  // R9 evicts B
    '{1'b1, 3'd2, HA, 3'd4, 1'b0, 1'b1, 1'b0, 3'd0, 4'd9},
    '{1'b1, 3'd1, HD, 3'd5, 1'b0, 1'b1, 1'b1, 3'd1, 4'd8},  // R8 B already gone
    '{1'b1, 3'd4, HD, 3'd5, 1'b0, 1'b1, 1'b0, 3'd0, 4'd9}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, flash_ready = 1'b0;
  logic [LW-1:0] cmd_lpn = '0;
  logic [HW-1:0] cmd_hash = '0;
  logic cmd_ready, done, done_hit, done_mapped, inval, flash_valid, stall, err;
  logic [PW-1:0] done_ppn, inval_ppn, flash_ppn;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dedup_write_ctrl #(
    .NUM_LPN(NL), .NUM_PPN(NP), .HASH_W(HW), .CACHE_DEPTH(CD), .REF_W(RW)
  ) u_dedup_write_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write), .cmd_lpn_i(cmd_lpn), .cmd_hash_i(cmd_hash),
    .cmd_ready_o(cmd_ready), .done_o(done), .done_hit_o(done_hit), .done_mapped_o(done_mapped),
    .done_ppn_o(done_ppn), .inval_o(inval), .inval_ppn_o(inval_ppn),
    .flash_req_valid_o(flash_valid), .flash_req_ppn_o(flash_ppn), .flash_req_ready_i(flash_ready),
    .stall_o(stall), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  logic g_done, g_hit, g_map, g_flash, g_inval;
  logic [PW-1:0] g_ppn, g_fppn, g_ippn;

  task automatic run_op(input logic wr, input logic [LW-1:0] lpn, input logic [HW-1:0] hash);
    int hold;
    g_done = 0; g_hit = 0; g_map = 0; g_flash = 0; g_inval = 0;
    g_ppn = '0; g_fppn = '0; g_ippn = '0;
    hold = 1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_lpn = lpn; cmd_hash = hash;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 20 && !g_done; k++) begin
      if (done) begin
        g_done = 1; g_hit = done_hit; g_map = done_mapped; g_ppn = done_ppn;
        g_inval = inval; g_ippn = inval_ppn; flash_ready = 1'b0;
      end else begin
        if (flash_valid) begin
          g_flash = 1; g_fppn = flash_ppn;
          if (hold == 0) flash_ready = 1'b1;
          else hold--;
        end
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(cmd_ready == 1'b1, "R5", "ready in reset", cmd_ready, 1);
    chk(flash_valid == 1'b0 && done == 1'b0, "R2", "no request in reset", flash_valid, 0);
    chk(stall == 1'b0, "R12", "no stall in reset", stall, 0);
    rst_ni = 1'b1;
    run_op(1'b0, 3'd3, '0);
    chk(g_done && !g_map, "R1", "unmapped read", g_map, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string rq;
      v  = VECS[i];
      rq = $sformatf("R%0d vec%0d", v.req, i);
      run_op(v.wr, v.lpn, v.hash);
      chk(g_done, rq, "done", g_done, 1);
      chk(g_ppn == v.ppn, rq, "ppn", g_ppn, v.ppn);
      chk(g_hit == v.hit, rq, "hit", g_hit, v.hit);
      chk(g_flash == v.flash, rq, "flash issued", g_flash, v.flash);
      if (v.flash) chk(g_fppn == v.ppn, rq, "flash ppn", g_fppn, v.ppn);
      chk(g_inval == v.inval, rq, "inval", g_inval, v.inval);
      if (v.inval) chk(g_ippn == v.ippn, rq, "inval ppn", g_ippn, v.ippn);
      if (!v.wr) chk(g_map, rq, "mapped", g_map, 1);
    end

    // R8 R11: dropping the evicted entry raised no error
    chk(err == 1'b0, "R11", "err after frees", err, 0);
    // R12: pool used up, evicted value B misses and waits
    chk(stall == 1'b1, "R12", "stall with pool empty", stall, 1);
    run_op(1'b1, 3'd3, HB);
    chk(!g_done, "R12", "miss does not finish", g_done, 0);
    chk(!g_flash, "R12", "no request when dry", g_flash, 0);
    chk(cmd_ready == 1'b0, "R5", "not ready while stalled", cmd_ready, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule